// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This unit sits between a 32-bit core's memory pipeline stage and a byte-addressed data memory whose port is one word wide. It takes one access at a time from the core: a base register value, a signed 16-bit displacement, a direction (read or write), an access width (byte, halfword or word) and, for reads, whether the narrow result is signed. From these it forms the effective address. It sends the memory a word-aligned address, per-lane byte enables and write data moved into the addressed lanes. When the read word comes back, it picks out the addressed lanes and widens them to 32 bits with sign or zero fill. Lane numbering is big-endian: address offset 0 is data bits [31:24].

An access whose effective address does not suit its width is never sent to memory. The unit instead raises a one-cycle error pulse. There is one pulse for reads and another for writes, and each comes with the faulting effective address, so the core can record it as the bad virtual address in its exception logic.

The request side and the memory request side use valid/ready. A request is accepted on a cycle where both `req_valid` and `req_ready` are high. The unit holds one access and keeps `req_ready` low until that access has finished. A memory request, once offered, keeps `mem_addr`, `mem_be`, `mem_wdata` and `mem_write` unchanged until `mem_ready` is seen. The read return path has no back-pressure. The memory raises `mem_rvalid` for one cycle per read, and the unit passes the result to the core combinationally in that same cycle, so the core must take it then.

Top module: `lsu_align_top`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around. `mem_addr` is that address with bits [1:0] forced to zero.
- R2: The width code on `req_size` is 00 for byte, 01 for halfword and 10 for word. Code 11 behaves exactly like word.
- R3: For a write, `mem_be` bit 3 enables data bits [31:24] (offset 0) and bit 0 enables bits [7:0] (offset 3). A byte sets only the bit for its offset. A halfword at offset 0 gives 1100 and at offset 2 gives 0011. A word gives 1111.
- R4: For a write, the low 8 bits (byte) or low 16 bits (halfword) of `req_wdata` are placed in the enabled lanes, and all other lanes of `mem_wdata` are zero. A word is passed through unchanged.
- R5: For a read, `ld_data` is the addressed byte or halfword taken from `mem_rdata` using the lane order of R3. It is sign-extended when `req_signed` was 1 and zero-extended when it was 0. A word read returns `mem_rdata` unchanged whatever the value of `req_signed`.
- R6: A halfword at an odd address, or a word whose address bits [1:0] are not 00, is misaligned. For such an access, in the cycle after acceptance, `err_load` (read) or `err_store` (write) is high for exactly one cycle, `err_addr` holds the effective address, and `mem_valid` stays low. Byte accesses are never misaligned.
- R7: While a misaligned write is being reported, `mem_be` is 0000.
- R8: `req_ready` is low from acceptance until the access completes: the error cycle for a misaligned access, the `mem_ready` handshake for a write, or `mem_rvalid` for a read. While `mem_valid` is high and `mem_ready` is low, the memory request outputs hold steady.
- R9: `ld_valid` is high only in a cycle where `mem_rvalid` is high while a read has been handed to memory and not yet answered. `mem_rvalid` at any other time produces no `ld_valid`.
- R10: After reset, `req_ready` is 1 and `mem_valid`, `ld_valid`, `err_load` and `err_store` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers an access |
| req_ready | output | 1 | Unit can accept an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access width code (R2) |
| req_signed | input | 1 | Read result is sign-extended when 1 |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Source register value for writes |
| mem_valid | output | 1 | Memory request offered |
| mem_ready | input | 1 | Memory takes the request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read word returned (one cycle) |
| mem_rdata | input | 32 | Returned read word |
| ld_valid | output | 1 | Extended read result valid |
| ld_data | output | 32 | Extended read result |
| err_load | output | 1 | Misaligned read reported |
| err_store | output | 1 | Misaligned write reported |
| err_addr | output | 32 | Faulting effective address |

## Verification
Misalignment detection and store lane steering act in the same cycle on a misaligned write. The error pulse must come out while the byte enables collapse to zero and no memory request appears. The stimulus provokes this with random base and displacement pairs, which land on every low-address pattern, together with directed odd-halfword and unaligned-word writes. Each such cycle is judged by sampling `err_store`, `err_addr`, `mem_valid` and `mem_be` together against values the bench derives from the effective address. It then confirms that the next request is accepted right away.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } lsu_size_e;
endpackage

// File: rtl/lsu_ea_check.sv
module lsu_ea_check #(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input  logic [XLEN-1:0]         base,
  input  logic [OFFW-1:0]         offset,
  input  lsu_align_pkg::lsu_size_e size,
  output logic [XLEN-1:0]         ea,
  output logic                    misaligned
);
  import lsu_align_pkg::*;
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  // R1: displacement sign-extended to full width, wrap-around add
  assign ea = base + {{(XLEN-OFFW){offset[OFFW-1]}}, offset};

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = ea[0];
      default: misaligned = |ea[LSB-1:0];   // R2: code 11 acts as word
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes #(
  parameter int XLEN = 32
) (
  input  lsu_align_pkg::lsu_size_e size,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic                      fault,
  input  logic [XLEN-1:0]           src,
  output logic [XLEN/8-1:0]         be,
  output logic [XLEN-1:0]           wdata
);
  import lsu_align_pkg::*;
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  logic [LSB-1:0] lane_h;
  int             sh_b, sh_h;

  assign lane_h = {lane[LSB-1:1], 1'b0};
  assign sh_b   = LANES - 1 - int'(lane);
  assign sh_h   = LANES - 2 - int'(lane_h);

  always_comb begin
    be    = '0;
    wdata = '0;
    unique case (size)
      SZ_BYTE: begin
        be    = {{(LANES-1){1'b0}}, 1'b1} << sh_b;
        wdata = {{(XLEN-8){1'b0}}, src[7:0]} << (8 * sh_b);
      end
      SZ_HALF: begin
        be    = {{(LANES-2){1'b0}}, 2'b11} << sh_h;
        wdata = {{(XLEN-16){1'b0}}, src[15:0]} << (8 * sh_h);
      end
      default: begin
        be    = '1;
        wdata = src;
      end
    endcase
    if (fault) be = '0;   // R7: faulting write touches no lane
  end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes #(
  parameter int XLEN = 32
) (
  input  lsu_align_pkg::lsu_size_e size,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic                      sgn,
  input  logic [XLEN-1:0]           rdata,
  output logic [XLEN-1:0]           result
);
  import lsu_align_pkg::*;
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  logic [LSB-1:0]  lane_h;
  logic [XLEN-1:0] sel_b, sel_h;

  assign lane_h = {lane[LSB-1:1], 1'b0};
  assign sel_b  = rdata >> (8 * (LANES - 1 - int'(lane)));
  assign sel_h  = rdata >> (8 * (LANES - 2 - int'(lane_h)));

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(XLEN-8){sgn & sel_b[7]}}, sel_b[7:0]};
      SZ_HALF: result = {{(XLEN-16){sgn & sel_h[15]}}, sel_h[15:0]};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top #(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic            req_signed,
  input  logic [XLEN-1:0] req_base,
  input  logic [OFFW-1:0] req_offset,
  input  logic [XLEN-1:0] req_wdata,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_write,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rvalid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            ld_valid,
  output logic [XLEN-1:0] ld_data,
  output logic            err_load,
  output logic            err_store,
  output logic [XLEN-1:0] err_addr
);
  import lsu_align_pkg::*;
  localparam int LANES = XLEN / 8;
  localparam int LSB   = $clog2(LANES);

  lsu_size_e       in_size;
  logic [XLEN-1:0] in_ea;
  logic            in_mis;

  logic            slot_v, slot_wait, slot_write, slot_sgn, slot_mis;
  lsu_size_e       slot_size;
  logic [XLEN-1:0] slot_ea, slot_src;

  assign in_size = lsu_size_e'(req_size);

  lsu_ea_check #(.XLEN(XLEN), .OFFW(OFFW)) u_ea (
    .base(req_base), .offset(req_offset), .size(in_size),
    .ea(in_ea), .misaligned(in_mis)
  );

  assign req_ready = !slot_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v     <= 1'b0;
      slot_wait  <= 1'b0;
      slot_write <= 1'b0;
      slot_sgn   <= 1'b0;
      slot_mis   <= 1'b0;
      slot_size  <= SZ_WORD;
      slot_ea    <= '0;
      slot_src   <= '0;
    end else if (req_valid && req_ready) begin
      slot_v     <= 1'b1;
      slot_wait  <= 1'b0;
      slot_write <= req_write;
      slot_sgn   <= req_signed;
      slot_mis   <= in_mis;
      slot_size  <= in_size;
      slot_ea    <= in_ea;
      slot_src   <= req_wdata;
    end else if (slot_v) begin
      if (slot_mis) begin
        slot_v <= 1'b0;
      end else if (mem_valid && mem_ready) begin
        if (slot_write) slot_v    <= 1'b0;
        else            slot_wait <= 1'b1;
      end else if (slot_wait && mem_rvalid) begin
        slot_v    <= 1'b0;
        slot_wait <= 1'b0;
      end
    end
  end

  assign mem_valid = slot_v && !slot_wait && !slot_mis;
  assign mem_write = slot_write;
  assign mem_addr  = {slot_ea[XLEN-1:LSB], {LSB{1'b0}}};

  lsu_store_lanes #(.XLEN(XLEN)) u_st (
    .size(slot_size), .lane(slot_ea[LSB-1:0]), .fault(slot_mis),
    .src(slot_src), .be(mem_be), .wdata(mem_wdata)
  );

  lsu_load_lanes #(.XLEN(XLEN)) u_ld (
    .size(slot_size), .lane(slot_ea[LSB-1:0]), .sgn(slot_sgn),
    .rdata(mem_rdata), .result(ld_data)
  );

  assign ld_valid  = slot_wait && mem_rvalid;
  assign err_load  = slot_v && slot_mis && !slot_write;
  assign err_store = slot_v && slot_mis && slot_write;
  assign err_addr  = slot_ea;

  // R8: one access in flight; request stable under back-pressure
  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
      $stable(mem_be) && $stable(mem_wdata) && $stable(mem_write));
  // R6: error is a single-cycle pulse with no memory traffic
  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_load || err_store) |=> !err_load && !err_store);
  assert_err_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_load || err_store) |-> !mem_valid && req_valid == req_valid);
  // R7: faulting write drives no enables
  assert_fault_no_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_store |-> mem_be == '0);
  // R3: a byte write enables exactly one lane
  assert_byte_one_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && slot_size == SZ_BYTE |-> $countones(mem_be) == 1);
  // R9: result only alongside a returned word
  assert_ld_with_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> mem_rvalid && !mem_valid);
  // R5: unsigned byte read clears the upper bits
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && slot_size == SZ_BYTE && !slot_sgn |-> ld_data[XLEN-1:8] == '0);
endmodule

// File: tb/lsu_align_top_tb.sv
module lsu_align_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_base = '0, req_wdata = '0;
  logic [15:0] req_offset = '0;
  logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, mem_valid, mem_write, ld_valid, err_load, err_store;
  logic [31:0] mem_addr, mem_wdata, ld_data, err_addr;
  logic [3:0]  mem_be;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  lsu_align_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .err_load(err_load), .err_store(err_store), .err_addr(err_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_mis(input logic [1:0] sz, input logic [31:0] ea);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return ea[0];
    return ea[1:0] != 2'b00;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'b00) begin
      case (off)
        2'd0: return 4'b1000;
        2'd1: return 4'b0100;
        2'd2: return 4'b0010;
        default: return 4'b0001;
      endcase
    end
    if (sz == 2'b01) return off[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] off,
                                         input logic [31:0] s);
    if (sz == 2'b00) begin
      case (off)
        2'd0: return {s[7:0], 24'h0};
        2'd1: return {8'h0, s[7:0], 16'h0};
        2'd2: return {16'h0, s[7:0], 8'h0};
        default: return {24'h0, s[7:0]};
      endcase
    end
    if (sz == 2'b01) return off[1] ? {16'h0, s[15:0]} : {s[15:0], 16'h0};
    return s;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic [1:0] off,
                                         input bit sg, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    case (off)
      2'd0: b = w[31:24];
      2'd1: b = w[23:16];
      2'd2: b = w[15:8];
      default: b = w[7:0];
    endcase
    h = off[1] ? w[15:0] : w[31:16];
    if (sz == 2'b00) return sg ? {{24{b[7]}}, b} : {24'h0, b};
    if (sz == 2'b01) return sg ? {{16{h[15]}}, h} : {16'h0, h};
    return w;
  endfunction

  task automatic access(input bit wr, input logic [1:0] sz, input bit sg,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] src, input logic [31:0] rword, input int stall);
    logic [31:0] ea;
    bit mis;
    ea  = base + {{16{off[15]}}, off};
    mis = is_mis(sz, ea);
    @(negedge clk);
    chk("R8 ready before request", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_base = base; req_offset = off; req_wdata = src;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_base = $urandom; req_wdata = $urandom;
    chk("R8 ready low while busy", {31'h0, req_ready}, 32'h0);
    if (mis) begin
      chk("R6 err_load", {31'h0, err_load}, {31'h0, !wr});
      chk("R6 err_store", {31'h0, err_store}, {31'h0, wr});
      chk("R6 err_addr", err_addr, ea);
      chk("R6 no mem_valid", {31'h0, mem_valid}, 32'h0);
      if (wr) chk("R7 no enables on fault", {28'h0, mem_be}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      chk("R6 pulse ends", {30'h0, err_load, err_store}, 32'h0);
      chk("R8 ready after error", {31'h0, req_ready}, 32'h1);
      return;
    end
    chk("R6 no error when aligned", {30'h0, err_load, err_store}, 32'h0);
    chk("R8 mem_valid", {31'h0, mem_valid}, 32'h1);
    chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
    chk("R8 mem_write", {31'h0, mem_write}, {31'h0, wr});
    if (wr) begin
      chk("R3 byte enables", {28'h0, mem_be}, {28'h0, exp_be(sz, ea[1:0])});
      chk("R4 write lanes", mem_wdata, exp_wd(sz, ea[1:0], src));
    end
    for (int i = 0; i < stall; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R8 held addr", mem_addr, {ea[31:2], 2'b00});
      chk("R8 held valid", {31'h0, mem_valid}, 32'h1);
      if (wr) chk("R8 held data", mem_wdata, exp_wd(sz, ea[1:0], src));
    end
    mem_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mem_ready = 1'b0;
    if (wr) begin
      chk("R8 ready after write", {31'h0, req_ready}, 32'h1);
      return;
    end
    chk("R8 mem_valid drops after read issue", {31'h0, mem_valid}, 32'h0);
    chk("R9 no result before return", {31'h0, ld_valid}, 32'h0);
    mem_rvalid = 1'b1; mem_rdata = rword;
    #1;
    chk("R9 ld_valid", {31'h0, ld_valid}, 32'h1);
    chk("R5 load extract", ld_data, exp_ld(sz, ea[1:0], sg, rword));
    @(posedge clk);
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R8 ready after read", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset ready", {31'h0, req_ready}, 32'h1);
    chk("R10 reset outputs", {28'h0, mem_valid, ld_valid, err_load, err_store}, 32'h0);
    rst_n = 1'b1;

    // R9: stray return with nothing outstanding
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    #1 chk("R9 stray rvalid ignored", {31'h0, ld_valid}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk("R9 stray leaves idle", {31'h0, req_ready}, 32'h1);

    // directed corners
    access(1'b1, 2'b00, 1'b0, 32'h1000_0000, 16'h0003, 32'h0000_00A5, 0, 0); // R3 lane 3
    access(1'b1, 2'b01, 1'b0, 32'h1000_0000, 16'h0002, 32'h1234_BEEF, 0, 2); // R4 half low
    access(1'b1, 2'b11, 1'b0, 32'h0000_0010, 16'hFFFC, 32'hCAFE_F00D, 0, 1); // R1 neg off, R2 code 11
    access(1'b1, 2'b01, 1'b0, 32'h2000_0000, 16'h0001, 32'hFFFF_FFFF, 0, 0); // R7 odd half write
    access(1'b1, 2'b10, 1'b0, 32'h2000_0002, 16'h0000, 32'h5555_AAAA, 0, 0); // R6 word off 2
    access(1'b0, 2'b10, 1'b1, 32'h3000_0001, 16'h0000, 0, 32'h0, 0);          // R6 read word
    access(1'b0, 2'b00, 1'b1, 32'h4000_0000, 16'h0001, 0, 32'h1180_2233, 0);  // R5 sign byte
    access(1'b0, 2'b00, 1'b0, 32'h4000_0000, 16'h0001, 0, 32'h1180_2233, 0);  // R5 zero byte
    access(1'b0, 2'b01, 1'b1, 32'h4000_0000, 16'h0002, 0, 32'h0000_9ABC, 1);  // R5 sign half
    access(1'b0, 2'b11, 1'b1, 32'hFFFF_FFFC, 16'h0004, 0, 32'h8765_4321, 0);  // R1 wrap, R5 word

    for (int n = 0; n < 400; n++) begin
      access(1'($urandom), 2'($urandom), 1'($urandom), $urandom, 16'($urandom),
             $urandom, $urandom, int'($urandom_range(0, 2)));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule